// File: doc/BRIEF.md
# Guard-Banded Cascaded Perceptron Classifier

This block labels one device under test from a vector of signed fixed-point measurements. It applies a measurement-select mask. It forms an extra feature equal to the sum of the squared masked measurements. It then evaluates a growing cascade of hard-threshold perceptrons. Layer k sees the masked measurements, the squared-magnitude feature and the binary decisions of every layer below it. A programmable top-layer index picks which layer acts as the network output, so a trained network can be trimmed back to a shallower depth without rewriting any coefficients.

Two such cascades hold separate coefficients and run one after the other on the same captured vector. When both report nominal the verdict is pass, and when both report faulty it is fail. When they disagree the device lies in the guard band and is sent to full retest. The datapath has a single multiply-accumulate and uses it once per cycle. A start strobe captures the vector and a one-cycle done strobe carries the verdict. Coefficients, the mask and the two top-layer indices are loaded through a plain write port while the block is idle.

Top module: `nc_guard_classifier`

## Requirements
- R1: After reset, done_o is 0 and result_o is 00. The mask resets to all ones and both top-layer indices reset to 0.
- R2: A mask bit k of 0 replaces measurement k by zero in every weighted sum and in the squared-magnitude feature.
- R3: The squared-magnitude feature is the exact sum of the squares of the masked measurements. It is weighted by coefficient index 8 of each layer.
- R4: Layer k also receives the decision of each earlier layer j of the same network, as 1 or 0, weighted by coefficient index 9+j. Coefficient indices 0..7 weight the measurements and index 24 is an added bias.
- R5: A perceptron fires (1 = nominal) when its weighted sum plus bias is greater than or equal to zero; otherwise it outputs 0. Sums are exact with no overflow.
- R6: The output of a network is the decision of the layer given by its top-layer index. Layers above that index have no effect on the result.
- R7: The verdict code is 00 when both networks fire, 01 when neither fires, and 10 (retest) when they differ.
- R8: done_o is a one-cycle pulse. It goes high exactly 8 + sum over both networks of sum for k = 0..T of (10 + k) rising edges after the edge that samples start_i, where T is that network's top-layer index.
- R9: While an evaluation is running, writes and further start strobes are ignored. The verdict and latency follow the coefficients that were in place at the start.
- R10: The write address decodes as follows. Bit 10 = 0 selects a coefficient at {network in bit 9, layer in bits 8:5, index in bits 4:0}. Bit 10 = 1 with low bits 0, 1 or 2 selects the mask (data bits 7:0), the top index of network 0, or the top index of network 1 (data bits 3:0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture the measurements and begin a classification |
| meas_i | input | 96 | Eight signed 12-bit measurements, measurement k at bits 12k+11:12k |
| wr_en_i | input | 1 | Write strobe for the configuration port |
| wr_addr_i | input | 11 | Configuration address |
| wr_data_i | input | 16 | Configuration data |
| done_o | output | 1 | One-cycle strobe when the verdict is valid |
| result_o | output | 2 | Verdict: 00 pass, 01 fail, 10 retest |

## Verification
The hardest case to reach from the ports is a configuration write, or a repeated start, landing in the middle of an evaluation. A block that wrongly accepts it can still give a plausible verdict. The stimulus sets both networks to fire from their bias alone. It then issues a write that would flip network 0, together with a second start, three cycles into a run. The bench checks that this run and the next undisturbed run still pass, and that the latency is unchanged. Directed vectors sit the weighted sum exactly at zero and at minus one, pile up the squared feature, and trim a two-layer network back to one layer. Seeded random coefficients, masks and depths then cover the remaining space, including an all-zero mask and the full sixteen-layer depth.

// File: rtl/nc_pkg.sv
package nc_pkg;

  typedef enum logic [1:0] {
    DEC_PASS   = 2'b00,
    DEC_FAIL   = 2'b01,
    DEC_RETEST = 2'b10
  } dec_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SQ,
    ST_MAC,
    ST_FIN
  } st_e;

  function automatic dec_e decide(input logic a, input logic b);
    if (a && b)        return DEC_PASS;
    else if (!a && !b) return DEC_FAIL;
    else               return DEC_RETEST;
  endfunction

endpackage

// File: rtl/nc_coef_store.sv
module nc_coef_store #(
  parameter int NMEAS = 8,
  parameter int WW    = 16,
  parameter int MAXL  = 16,
  parameter int NCOEF = 25,
  parameter int LW    = 4,
  parameter int IDXW  = 5,
  parameter int AW    = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [WW-1:0]        wr_data_i,
  input  logic                 rd_net_i,
  input  logic [LW-1:0]        rd_layer_i,
  input  logic [IDXW-1:0]      rd_idx_i,
  output logic signed [WW-1:0] coef_o,
  output logic [NMEAS-1:0]     mask_o,
  output logic [LW-1:0]        top0_o,
  output logic [LW-1:0]        top1_o
);

  localparam int DEPTH = 2 * MAXL * NCOEF;
  localparam int FW    = $clog2(DEPTH);

  logic [WW-1:0]    mem_q [DEPTH];
  logic [NMEAS-1:0] mask_q, mask_d;
  logic [LW-1:0]    top0_q, top0_d, top1_q, top1_d;

  logic             acc_wr, is_ctrl, coef_we;
  logic             w_net;
  logic [LW-1:0]    w_layer;
  logic [IDXW-1:0]  w_idx;
  logic [FW-1:0]    w_flat, r_flat;

  assign acc_wr  = wr_en_i && !busy_i;
  assign is_ctrl = wr_addr_i[AW-1];
  assign w_net   = wr_addr_i[LW+IDXW];
  assign w_layer = wr_addr_i[IDXW +: LW];
  assign w_idx   = wr_addr_i[IDXW-1:0];
  assign coef_we = acc_wr && !is_ctrl && (w_idx < IDXW'(NCOEF));

  assign w_flat = FW'(int'(w_net) * MAXL * NCOEF + int'(w_layer) * NCOEF + int'(w_idx));
  assign r_flat = FW'(int'(rd_net_i) * MAXL * NCOEF + int'(rd_layer_i) * NCOEF + int'(rd_idx_i));

  always_ff @(posedge clk) begin
    if (coef_we) mem_q[w_flat] <= wr_data_i;
  end

  assign coef_o = $signed(mem_q[r_flat]);

  always_comb begin
    mask_d = mask_q;
    top0_d = top0_q;
    top1_d = top1_q;
    if (acc_wr && is_ctrl) begin
      case (wr_addr_i[1:0])
        2'd0:    mask_d = wr_data_i[NMEAS-1:0];
        2'd1:    top0_d = wr_data_i[LW-1:0];
        2'd2:    top1_d = wr_data_i[LW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      top0_q <= '0;
      top1_q <= '0;
    end else begin
      mask_q <= mask_d;
      top0_q <= top0_d;
      top1_q <= top1_d;
    end
  end

  assign mask_o = mask_q;
  assign top0_o = top0_q;
  assign top1_o = top1_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(mask_q) && $stable(top0_q) && $stable(top1_q))); // R9

endmodule

// File: rtl/nc_mac_path.sv
module nc_mac_path #(
  parameter int NMEAS = 8,
  parameter int MW    = 12,
  parameter int WW    = 16,
  parameter int MAXL  = 16,
  parameter int LW    = 4,
  parameter int IDXW  = 5,
  parameter int SQW   = 27,
  parameter int ACCW  = 49
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [NMEAS*MW-1:0]  meas_i,
  input  logic [NMEAS-1:0]     mask_i,
  input  logic                 sq_en_i,
  input  logic                 acc_clr_i,
  input  logic                 acc_en_i,
  input  logic [IDXW-1:0]      idx_i,
  input  logic signed [WW-1:0] coef_i,
  input  logic [MAXL-1:0]      prev_i,
  output logic                 fire_o
);

  localparam int MIDXW = $clog2(NMEAS);
  localparam logic [IDXW-1:0] IDX_SQ = IDXW'(NMEAS);
  localparam logic [IDXW-1:0] IDX_P0 = IDXW'(NMEAS + 1);

  logic signed [MW-1:0]   gated [NMEAS];
  logic signed [MW-1:0]   xm_q  [NMEAS];
  logic signed [SQW-1:0]  sq_q, sq_d;
  logic signed [ACCW-1:0] acc_q, acc_d;
  logic signed [MW-1:0]   xm_sel;
  logic signed [SQW-1:0]  xm_ext;
  logic signed [SQW:0]    term;
  logic signed [ACCW-1:0] prod;
  logic [IDXW-1:0]        pidx;

  for (genvar k = 0; k < NMEAS; k++) begin : g_gate
    assign gated[k] = mask_i[k] ? $signed(meas_i[k*MW +: MW]) : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      xm_q[k] <= '0;
      else if (load_i) xm_q[k] <= gated[k];
    end
  end

  assign xm_sel = xm_q[idx_i[MIDXW-1:0]];
  assign xm_ext = SQW'(xm_sel);
  assign pidx   = idx_i - IDX_P0;

  always_comb begin
    if (idx_i < IDX_SQ)       term = (SQW+1)'(xm_sel);
    else if (idx_i == IDX_SQ) term = (SQW+1)'(sq_q);
    else                      term = prev_i[pidx[LW-1:0]] ? (SQW+1)'(1) : '0;
  end

  assign prod = ACCW'(coef_i) * ACCW'(term);

  always_comb begin
    sq_d  = sq_q;
    acc_d = acc_q;
    if (load_i)       sq_d = '0;
    else if (sq_en_i) sq_d = sq_q + xm_ext * xm_ext;
    if (acc_clr_i)     acc_d = '0;
    else if (acc_en_i) acc_d = acc_q + prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q  <= '0;
      acc_q <= '0;
    end else begin
      sq_q  <= sq_d;
      acc_q <= acc_d;
    end
  end

  assign fire_o = (acc_q + ACCW'(coef_i)) >= 0;

  AST_SQ_NONDECREASING: assert property (@(posedge clk) disable iff (!rst_n)
    sq_en_i |=> (sq_q >= $past(sq_q))); // R3

endmodule

// File: rtl/nc_seq.sv
module nc_seq
  import nc_pkg::*;
#(
  parameter int NMEAS = 8,
  parameter int MAXL  = 16,
  parameter int NCOEF = 25,
  parameter int LW    = 4,
  parameter int IDXW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [LW-1:0]   top0_i,
  input  logic [LW-1:0]   top1_i,
  input  logic            fire_i,
  output logic            busy_o,
  output logic            load_o,
  output logic            sq_en_o,
  output logic            acc_clr_o,
  output logic            acc_en_o,
  output logic            rd_net_o,
  output logic [LW-1:0]   rd_layer_o,
  output logic [IDXW-1:0] rd_idx_o,
  output logic [MAXL-1:0] prev_o,
  output logic            done_o,
  output logic [1:0]      result_o
);

  localparam logic [IDXW-1:0] IDX_LASTM = IDXW'(NMEAS - 1);
  localparam logic [IDXW-1:0] IDX_BIAS  = IDXW'(NCOEF - 1);

  st_e             st_q, st_d;
  logic            net_q, net_d;
  logic [LW-1:0]   layer_q, layer_d, top_sel;
  logic [IDXW-1:0] idx_q, idx_d, idx_end;
  logic [MAXL-1:0] outs_q, outs_d;
  logic            res0_q, res0_d, done_q, done_d;
  dec_e            result_q, result_d;

  assign top_sel = net_q ? top1_i : top0_i;
  assign idx_end = IDXW'(NMEAS) + {{(IDXW-LW){1'b0}}, layer_q};

  always_comb begin
    st_d      = st_q;
    net_d     = net_q;
    layer_d   = layer_q;
    idx_d     = idx_q;
    outs_d    = outs_q;
    res0_d    = res0_q;
    result_d  = result_q;
    done_d    = 1'b0;
    load_o    = 1'b0;
    sq_en_o   = 1'b0;
    acc_clr_o = 1'b0;
    acc_en_o  = 1'b0;
    rd_idx_o  = idx_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          idx_d  = '0;
          st_d   = ST_SQ;
        end
      end
      ST_SQ: begin
        sq_en_o = 1'b1;
        if (idx_q == IDX_LASTM) begin
          idx_d     = '0;
          net_d     = 1'b0;
          layer_d   = '0;
          acc_clr_o = 1'b1;
          st_d      = ST_MAC;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_MAC: begin
        acc_en_o = 1'b1;
        if (idx_q == idx_end) st_d = ST_FIN;
        else                  idx_d = idx_q + 1'b1;
      end
      default: begin
        rd_idx_o        = IDX_BIAS;
        outs_d[layer_q] = fire_i;
        acc_clr_o       = 1'b1;
        idx_d           = '0;
        st_d            = ST_MAC;
        if (layer_q == top_sel) begin
          layer_d = '0;
          if (!net_q) begin
            res0_d = fire_i;
            net_d  = 1'b1;
          end else begin
            done_d   = 1'b1;
            result_d = decide(res0_q, fire_i);
            st_d     = ST_IDLE;
          end
        end else begin
          layer_d = layer_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      net_q    <= 1'b0;
      layer_q  <= '0;
      idx_q    <= '0;
      outs_q   <= '0;
      res0_q   <= 1'b0;
      done_q   <= 1'b0;
      result_q <= DEC_PASS;
    end else begin
      st_q     <= st_d;
      net_q    <= net_d;
      layer_q  <= layer_d;
      idx_q    <= idx_d;
      outs_q   <= outs_d;
      res0_q   <= res0_d;
      done_q   <= done_d;
      result_q <= result_d;
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign rd_net_o   = net_q;
  assign rd_layer_o = layer_q;
  assign prev_o     = outs_q;
  assign done_o     = done_q;
  assign result_o   = result_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (result_q != 2'b11)); // R7
  AST_LAYER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_MAC) || (st_q == ST_FIN)) |-> (layer_q <= top_sel)); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_d) |=> busy_o); // R9

endmodule

// File: rtl/nc_guard_classifier.sv
module nc_guard_classifier #(
  parameter  int NMEAS = 8,
  parameter  int MW    = 12,
  parameter  int WW    = 16,
  parameter  int MAXL  = 16,
  localparam int LW    = $clog2(MAXL),
  localparam int NCOEF = NMEAS + MAXL + 1,
  localparam int IDXW  = $clog2(NCOEF),
  localparam int AW    = IDXW + LW + 2,
  localparam int SQW   = 2 * MW + $clog2(NMEAS),
  localparam int ACCW  = WW + SQW + 1 + $clog2(NCOEF)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [NMEAS*MW-1:0] meas_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [WW-1:0]       wr_data_i,
  output logic                done_o,
  output logic [1:0]          result_o
);

  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic                 busy, load, sq_en, acc_clr, acc_en, fire, rd_net;
  logic [LW-1:0]        rd_layer, top0, top1;
  logic [IDXW-1:0]      rd_idx;
  logic signed [WW-1:0] coef;
  logic [NMEAS-1:0]     mask;
  logic [MAXL-1:0]      prev;

  nc_coef_store #(.NMEAS(NMEAS), .WW(WW), .MAXL(MAXL), .NCOEF(NCOEF),
                  .LW(LW), .IDXW(IDXW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_s_q), .busy_i(busy), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_net_i(rd_net),
    .rd_layer_i(rd_layer), .rd_idx_i(rd_idx), .coef_o(coef),
    .mask_o(mask), .top0_o(top0), .top1_o(top1));

  nc_mac_path #(.NMEAS(NMEAS), .MW(MW), .WW(WW), .MAXL(MAXL), .LW(LW),
                .IDXW(IDXW), .SQW(SQW), .ACCW(ACCW)) u_path (
    .clk(clk), .rst_n(rst_s_q), .load_i(load), .meas_i(meas_i),
    .mask_i(mask), .sq_en_i(sq_en), .acc_clr_i(acc_clr), .acc_en_i(acc_en),
    .idx_i(rd_idx), .coef_i(coef), .prev_i(prev), .fire_o(fire));

  nc_seq #(.NMEAS(NMEAS), .MAXL(MAXL), .NCOEF(NCOEF), .LW(LW),
           .IDXW(IDXW)) u_seq (
    .clk(clk), .rst_n(rst_s_q), .start_i(start_i), .top0_i(top0),
    .top1_i(top1), .fire_i(fire), .busy_o(busy), .load_o(load),
    .sq_en_o(sq_en), .acc_clr_o(acc_clr), .acc_en_o(acc_en),
    .rd_net_o(rd_net), .rd_layer_o(rd_layer), .rd_idx_o(rd_idx),
    .prev_o(prev), .done_o(done_o), .result_o(result_o));

endmodule

// File: tb/nc_guard_classifier_tb_top.sv
module nc_guard_classifier_tb_top;

  localparam int NMEAS = 8;
  localparam int MW    = 12;
  localparam int WW    = 16;
  localparam int MAXL  = 16;
  localparam int NCOEF = 25;
  localparam int AW    = 11;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rst_n, start, wr_en, done;
  logic [NMEAS*MW-1:0] meas;
  logic [AW-1:0]       wr_addr;
  logic [WW-1:0]       wr_data;
  logic [1:0]          result;

  nc_guard_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .meas_i(meas),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .done_o(done), .result_o(result));

  int checks = 0;
  int errors = 0;

  logic signed [WW-1:0] wt [2][MAXL][NCOEF];
  int                   top_r [2];
  logic [NMEAS-1:0]     msk;
  logic signed [MW-1:0] xv [NMEAS];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic net_eval(input int n);
    longint sq = 0;
    longint xm [NMEAS];
    logic   bits [MAXL];
    for (int k = 0; k < NMEAS; k++) begin
      xm[k] = msk[k] ? longint'(xv[k]) : 0;
      sq += xm[k] * xm[k];
    end
    for (int l = 0; l <= top_r[n]; l++) begin
      longint acc = 0;
      for (int k = 0; k < NMEAS; k++) acc += longint'(wt[n][l][k]) * xm[k];
      acc += longint'(wt[n][l][NMEAS]) * sq;
      for (int j = 0; j < l; j++) if (bits[j]) acc += longint'(wt[n][l][NMEAS+1+j]);
      acc += longint'(wt[n][l][NCOEF-1]);
      bits[l] = (acc >= 0);
    end
    return bits[top_r[n]];
  endfunction

  function automatic logic [1:0] model_dec();
    logic a = net_eval(0);
    logic b = net_eval(1);
    if (a && b)   return 2'b00;
    if (!a && !b) return 2'b01;
    return 2'b10;
  endfunction

  function automatic int model_lat();
    int lat = NMEAS;
    for (int n = 0; n < 2; n++)
      for (int k = 0; k <= top_r[n]; k++) lat += NMEAS + 2 + k;
    return lat;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R10: coefficient address {0, net, layer, index}; control address 1_xxx with low bits 0/1/2
  task automatic load_all();
    for (int n = 0; n < 2; n++)
      for (int l = 0; l < MAXL; l++)
        for (int i = 0; i < NCOEF; i++)
          wr({1'b0, n[0], l[3:0], i[4:0]}, wt[n][l][i]);
    wr(11'h400, {8'h00, msk});
    wr(11'h401, 16'(top_r[0]));
    wr(11'h402, 16'(top_r[1]));
  endtask

  task automatic clear_cfg();
    for (int n = 0; n < 2; n++) begin
      top_r[n] = 0;
      for (int l = 0; l < MAXL; l++)
        for (int i = 0; i < NCOEF; i++) wt[n][l][i] = '0;
    end
    msk = '1;
    for (int k = 0; k < NMEAS; k++) xv[k] = '0;
  endtask

  task automatic run(input string req, input bit disturb, output logic [1:0] res);
    int n = 0;
    logic [1:0] exp_r = model_dec();
    int exp_l = model_lat();
    for (int k = 0; k < NMEAS; k++) meas[k*MW +: MW] = xv[k];
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (disturb && n == 3) begin
        wr_en = 1'b1; wr_addr = 11'd24; wr_data = 16'h8000; start = 1'b1;
      end
      if (disturb && n == 4) begin
        wr_en = 1'b0; start = 1'b0;
      end
    end
    res = result;
    check(done === 1'b1 && result === exp_r, req, "verdict vs model", longint'(result), longint'(exp_r));
    check(n == exp_l, "R8", "latency", n, exp_l);
    @(negedge clk);
    check(done === 1'b0, "R8", "done pulse width", longint'(done), 0);
  endtask

  initial begin
    #700us;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; meas = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && result === 2'b00, "R1", "reset outputs", longint'({done, result}), 0);

    // R1 reset defaults: mask all ones, tops 0; only biases configured
    clear_cfg();
    for (int n = 0; n < 2; n++)
      for (int l = 0; l < MAXL; l++)
        for (int i = 0; i < NCOEF; i++) wr({1'b0, n[0], l[3:0], i[4:0]}, 16'h0000);
    xv[0] = 12'sd7;
    run("R1", 1'b0, r);

    // R5 threshold at exactly zero fires, at -1 does not; R7 codes
    wt[0][0][24] = 16'sd0;  wt[1][0][24] = 16'sd0;  load_all();
    run("R5", 1'b0, r); check(r === 2'b00, "R5", "sum zero fires", r, 0);
    wt[0][0][24] = -16'sd1; wt[1][0][24] = -16'sd1; load_all();
    run("R7", 1'b0, r); check(r === 2'b01, "R7", "both faulty", r, 1);
    wt[0][0][24] = 16'sd0;  load_all();
    run("R7", 1'b0, r); check(r === 2'b10, "R7", "disagree retest", r, 2);

    // R3 squared feature, R2 mask
    clear_cfg();
    for (int n = 0; n < 2; n++) begin wt[n][0][8] = 16'sd1; wt[n][0][24] = -16'sd100; end
    xv[0] = 12'sd6; xv[3] = 12'sd8; load_all();
    run("R3", 1'b0, r); check(r === 2'b00, "R3", "36+64 reaches 100", r, 0);
    xv[3] = -12'sd7; load_all();
    run("R3", 1'b0, r); check(r === 2'b01, "R3", "36+49 short", r, 1);
    xv[3] = -12'sd8; msk = 8'hF7; load_all();
    run("R2", 1'b0, r); check(r === 2'b01, "R2", "masked input dropped", r, 1);
    clear_cfg();
    wt[0][0][2] = 16'sd1; wt[1][0][2] = 16'sd1; xv[2] = -12'sd5; load_all();
    run("R2", 1'b0, r); check(r === 2'b01, "R2", "negative measurement", r, 1);
    msk = 8'hFB; load_all();
    run("R2", 1'b0, r); check(r === 2'b00, "R2", "masked weighted term", r, 0);

    // R4 earlier-layer feedback, R6 top-layer selection
    clear_cfg();
    for (int n = 0; n < 2; n++) begin wt[n][1][9] = -16'sd1; top_r[n] = 1; end
    load_all();
    run("R4", 1'b0, r); check(r === 2'b01, "R4", "layer0 output feeds layer1", r, 1);
    top_r[0] = 0; top_r[1] = 0; load_all();
    run("R6", 1'b0, r); check(r === 2'b00, "R6", "cut back to layer0", r, 0);

    // R9 write and start during evaluation ignored
    clear_cfg();
    wt[0][0][24] = 16'sd5; wt[1][0][24] = 16'sd5; load_all();
    run("R9", 1'b1, r); check(r === 2'b00, "R9", "disturbed run", r, 0);
    run("R9", 1'b0, r); check(r === 2'b00, "R9", "write was dropped", r, 0);

    // random coverage incl. zero mask and deepest network (R4 R5 R6 R10)
    for (int t = 0; t < 40; t++) begin
      for (int n = 0; n < 2; n++) begin
        top_r[n] = (t == 0) ? MAXL - 1 : int'($urandom_range(0, MAXL - 1));
        for (int l = 0; l < MAXL; l++)
          for (int i = 0; i < NCOEF; i++)
            wt[n][l][i] = (i == 8) ? 16'($signed($urandom_range(0, 32)) - 16)
                                   : 16'($urandom);
      end
      msk = (t % 10 == 5) ? 8'h00 : 8'($urandom);
      for (int k = 0; k < NMEAS; k++) xv[k] = 12'($urandom);
      load_all();
      run("R6", 1'b0, r);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule